// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits between the qualified write strobes of a byte-wide nonvolatile memory and its page-load engine. Each write arrives as an address and data pair. The guard decides on the spot whether that byte may enter the page buffer. It watches for two multi-write command sequences. A three-write prefix both locks the memory and authorises the load that carries it. A six-write sequence unlocks the memory.

A load is a run of writes, and each write must come within a fixed window of the one before. When the window lapses, the load closes. If the load held anything to act on, the guard pulses the start of the internal programming period. This includes stored bytes, bytes that were refused, and a completed command. The protection flag changes only when that period ends. The flag is kept in a register that the ordinary reset does not touch, which stands in for nonvolatile retention.

While protection is on, a load gets through only if it begins with the lock prefix. A load without the prefix still starts the programming timer, but no byte of it reaches the buffer. Command bytes themselves are never stored. The command addresses remain ordinary cells that plain data writes may use.

Top module: `prot_seq_guard`

## Requirements
- R1: The writes 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, as the opening writes of a load, set `prot_on`. The change appears only after the programming period that follows the load, and `prot_on` is still unchanged in the cycle `prog_start` is high.
- R2: The six opening writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clear `prot_on` at the end of the programming period that follows the load.
- R3: A write consumed as a step of either command sequence never asserts `byte_pass`.
- R4: While `prot_on` is 0, a write that is not a command step asserts `byte_pass` in its own cycle.
- R5: While `prot_on` is 1, the writes of a load that lacks the prefix all see `byte_pass` low. When that load closes, `prog_start` still pulses once, and `prot_on` keeps its value.
- R6: While `prot_on` is 1, the bytes that follow a completed prefix, or a completed six-write sequence, in the same load assert `byte_pass`.
- R7: A write that breaks a partly matched sequence ends the match for the rest of the load. That write, and every later one in the load, is treated as an ordinary write under the current `prot_on`.
- R8: A load closes BLC_CYCLES cycles after its last write, and `prog_start` is high exactly in that cycle if the load needs programming. A load made only of an incomplete command prefix raises no `prog_start` and leaves `prot_on` unchanged. The match does not carry over into the next load.
- R9: `prot_on` starts at PROT_INIT (0), and asserting `rst_n` does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of sequencing state (not of the flag) |
| wr_vld | input | 1 | One qualified write strobe this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| byte_pass | output | 1 | This cycle's write goes to the page buffer |
| prog_start | output | 1 | One-cycle pulse that starts the programming period |
| prot_on | output | 1 | Current write-protection state |

## Verification
Suppose the sequence position or the alive bit is wrong. Then `byte_pass` takes the wrong value in the very cycle of the next write. It either lets a command byte through or blocks a data byte after a valid prefix. A wrong pending update stays hidden until the programming period ends. It shows as a wrong `prot_on` one cycle after that period. A wrong need flag or a wrong window count shows within BLC_CYCLES cycles of the last write, as a missing, extra or mistimed `prog_start`.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_PROG = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_SET  = 2'd1,
      UPD_CLR  = 2'd2
   } upd_e;

   localparam int unsigned SEQ_LEN  = 6;
   localparam int unsigned FORK_POS = 2;

   localparam logic [7:0] KEY_OPEN  = 8'hAA;
   localparam logic [7:0] KEY_SWAP  = 8'h55;
   localparam logic [7:0] KEY_LOCK  = 8'hA0;
   localparam logic [7:0] KEY_EXT   = 8'h80;
   localparam logic [7:0] KEY_FREE  = 8'h20;

   // 1: the step targets the primary command address, 0: the secondary
   function automatic logic step_on_primary(input int unsigned k);
      return !((k == 1) || (k == 4));
   endfunction

   // data key of each step; the fork step lists its continuing key
   function automatic logic [7:0] step_key(input int unsigned k);
      case (k)
         0, 3:    return KEY_OPEN;
         1, 4:    return KEY_SWAP;
         2:       return KEY_EXT;
         default: return KEY_FREE;
      endcase
   endfunction

endpackage

// File: rtl/seq_matcher.sv
module seq_matcher
   import prot_seq_pkg::*;
#(
   parameter int unsigned     AW     = 15,
   parameter int unsigned     DW     = 8,
   parameter logic [AW-1:0]   ADDR_P = 'h5555,
   parameter logic [AW-1:0]   ADDR_S = 'h2AAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          clr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   input  logic          prot,
   output logic          hit,
   output logic          pass,
   output logic          need,
   output upd_e          pend
);

   localparam int unsigned PW = $clog2(SEQ_LEN);

   logic [PW-1:0] pos_q;
   logic          alive_q;
   logic          armed_q;
   logic          touch_q;
   upd_e          pend_q;

   logic [AW-1:0] exp_addr;
   logic [DW-1:0] exp_key;
   logic          key_ok;
   logic          lock_ok;
   logic          last_step;

   always_comb begin
      exp_addr  = step_on_primary(int'(pos_q)) ? ADDR_P : ADDR_S;
      exp_key   = DW'(step_key(int'(pos_q)));
      key_ok    = (data == exp_key);
      lock_ok   = (pos_q == PW'(FORK_POS)) && (data == DW'(KEY_LOCK));
      last_step = (pos_q == PW'(SEQ_LEN - 1));
      hit       = acc && alive_q && (addr == exp_addr) && (key_ok || lock_ok);
      pass      = acc && !hit && (armed_q || !prot);
      need      = touch_q || (pend_q != UPD_NONE);
      pend      = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         alive_q <= 1'b1;
         armed_q <= 1'b0;
         touch_q <= 1'b0;
         pend_q  <= UPD_NONE;
      end else if (clr) begin
         pos_q   <= '0;
         alive_q <= 1'b1;
         armed_q <= 1'b0;
         touch_q <= 1'b0;
         pend_q  <= UPD_NONE;
      end else if (acc) begin
         if (hit) begin
            if (lock_ok) begin
               pend_q  <= UPD_SET;
               armed_q <= 1'b1;
               alive_q <= 1'b0;
            end else if (last_step) begin
               pend_q  <= UPD_CLR;
               armed_q <= 1'b1;
               alive_q <= 1'b0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end else begin
            alive_q <= 1'b0;
            touch_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/load_window.sv
module load_window #(
   parameter int unsigned BLC_CYCLES = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   input  logic en,
   output logic expire
);

   localparam int unsigned CW = $clog2(BLC_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(BLC_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (BLC_CYCLES < 2) begin : g_bad_window
         $error("load_window: BLC_CYCLES must be at least 2");
      end
   endgenerate

   assign expire = en && !kick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (kick)         cnt_q <= '0;
      else if (en && !expire) cnt_q <= cnt_q + 1'b1;
      else if (expire)       cnt_q <= '0;
   end

endmodule

// File: rtl/prog_period.sv
module prog_period
   import prot_seq_pkg::*;
#(
   parameter int unsigned PROG_CYCLES = 2500,
   parameter bit          PROT_INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  upd_e upd,
   output logic busy,
   output logic done,
   output logic prot
);

   localparam int unsigned CW = $clog2(PROG_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   upd_e          upd_q;
   logic          prot_q = PROT_INIT;

   generate
      if (PROG_CYCLES < 2) begin : g_bad_period
         $error("prog_period: PROG_CYCLES must be at least 2");
      end
   endgenerate

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == LAST);
   assign prot = prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         upd_q  <= UPD_NONE;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         upd_q  <= upd;
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         upd_q  <= UPD_NONE;
      end else if (busy_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // retained flag: no reset term, stands for the nonvolatile bit
   always_ff @(posedge clk) begin
      if (done && (upd_q == UPD_SET))      prot_q <= 1'b1;
      else if (done && (upd_q == UPD_CLR)) prot_q <= 1'b0;
   end

endmodule

// File: rtl/prot_seq_guard.sv
module prot_seq_guard
   import prot_seq_pkg::*;
#(
   parameter int unsigned   AW          = 15,
   parameter int unsigned   DW          = 8,
   parameter logic [AW-1:0] ADDR_P      = 'h5555,
   parameter logic [AW-1:0] ADDR_S      = 'h2AAA,
   parameter int unsigned   BLC_CYCLES  = 600,
   parameter int unsigned   PROG_CYCLES = 2500,
   parameter bit            PROT_INIT   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_vld,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          byte_pass,
   output logic          prog_start,
   output logic          prot_on
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("prot_seq_guard: DW must hold an 8-bit key");
      end
      if (ADDR_P == ADDR_S) begin : g_bad_addr
         $error("prot_seq_guard: command addresses must differ");
      end
   endgenerate

   phase_e phase;
   logic   acc;
   logic   hit;
   logic   need;
   logic   expire;
   logic   busy;
   logic   done;
   upd_e   pend;

   assign acc        = wr_vld && (phase != PH_PROG);
   assign prog_start = expire && need;

   seq_matcher #(
      .AW(AW), .DW(DW), .ADDR_P(ADDR_P), .ADDR_S(ADDR_S)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .acc(acc), .clr(expire),
      .addr(wr_addr), .data(wr_data), .prot(prot_on),
      .hit(hit), .pass(byte_pass), .need(need), .pend(pend)
   );

   load_window #(.BLC_CYCLES(BLC_CYCLES)) u_win (
      .clk(clk), .rst_n(rst_n), .kick(acc),
      .en(phase == PH_LOAD), .expire(expire)
   );

   prog_period #(.PROG_CYCLES(PROG_CYCLES), .PROT_INIT(PROT_INIT)) u_prog (
      .clk(clk), .rst_n(rst_n), .start(prog_start), .upd(pend),
      .busy(busy), .done(done), .prot(prot_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         case (phase)
            PH_IDLE: if (acc)    phase <= PH_LOAD;
            PH_LOAD: if (expire) phase <= need ? PH_PROG : PH_IDLE;
            PH_PROG: if (done)   phase <= PH_IDLE;
            default:             phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/prot_seq_chk.sv
module prot_seq_chk
   import prot_seq_pkg::*;
#(
   parameter int unsigned   AW     = 15,
   parameter int unsigned   DW     = 8,
   parameter logic [AW-1:0] ADDR_P = 'h5555
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_vld,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          byte_pass,
   input logic          prog_start,
   input logic          prot_on,
   input phase_e        phase,
   input logic          busy
);

   logic opens;
   assign opens = (wr_addr == ADDR_P) && (wr_data == DW'(KEY_OPEN));

   // R4
   pass_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_pass |-> wr_vld);

   // R1
   flag_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_on) |-> ($past(phase) == PH_PROG) && (phase == PH_IDLE));

   // R3
   opener_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && phase == PH_IDLE && opens) |-> !byte_pass);

   // R5
   locked_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && phase == PH_IDLE && prot_on && !opens) |-> !byte_pass);

   // R8
   start_at_quiet_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (phase == PH_LOAD) && !wr_vld);

   // R8
   start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start && busy);

   // R5
   quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !byte_pass && !prog_start);

endmodule

bind prot_seq_guard prot_seq_chk #(.AW(AW), .DW(DW), .ADDR_P(ADDR_P)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
   .wr_data(wr_data), .byte_pass(byte_pass), .prog_start(prog_start),
   .prot_on(prot_on), .phase(phase), .busy(busy)
);

// File: tb/tb_prot_seq_guard.sv
module tb_prot_seq_guard;

   localparam int AW  = 15;
   localparam int DW  = 8;
   localparam int BLC = 24;
   localparam int PRG = 48;
   localparam logic [14:0] AP = 15'h5555;
   localparam logic [14:0] AS = 15'h2AAA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_vld = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          byte_pass, prog_start, prot_on;

   int n_chk = 0, n_fail = 0, n_prog = 0;

   // reference model state
   bit m_prot = 1'b0;
   int m_pos = 0;
   bit m_alive = 1'b1, m_armed = 1'b0, m_touch = 1'b0;
   int m_pend = 0;   // 0 none, 1 set, 2 clear

   always #2 clk = ~clk;

   prot_seq_guard #(.BLC_CYCLES(BLC), .PROG_CYCLES(PRG)) dut (
      .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
      .wr_data(wr_data), .byte_pass(byte_pass), .prog_start(prog_start),
      .prot_on(prot_on)
   );

   always @(negedge clk) if (prog_start) n_prog++;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [14:0] m_addr(int k);
      return (k == 1 || k == 4) ? AS : AP;
   endfunction

   function automatic logic [7:0] m_key(int k);
      case (k)
         0, 3: return 8'hAA;
         1, 4: return 8'h55;
         2:    return 8'h80;
         default: return 8'h20;
      endcase
   endfunction

   function automatic bit mdl_wr(logic [14:0] a, logic [7:0] d, output string req);
      bit lock, hit;
      lock = (m_pos == 2) && (d == 8'hA0);
      hit  = m_alive && (a == m_addr(m_pos)) && ((d == m_key(m_pos)) || lock);
      if (hit) begin
         req = "R3";
         if (lock) begin m_pend = 1; m_armed = 1; m_alive = 0; end
         else if (m_pos == 5) begin m_pend = 2; m_armed = 1; m_alive = 0; end
         else m_pos++;
         return 1'b0;
      end
      req = (m_pos != 0 && m_alive) ? "R7" : (m_armed ? "R6" : (m_prot ? "R5" : "R4"));
      m_alive = 0;
      m_touch = 1;
      return m_armed || !m_prot;
   endfunction

   task automatic mdl_clear();
      m_pos = 0; m_alive = 1; m_armed = 0; m_touch = 0; m_pend = 0;
   endtask

   task automatic wr(logic [14:0] a, logic [7:0] d);
      bit exp;
      string req;
      @(negedge clk);
      wr_vld = 1'b1; wr_addr = a; wr_data = d;
      exp = mdl_wr(a, d, req);
      #1 chk(byte_pass == exp, req, "byte_pass", byte_pass, exp);
      @(negedge clk);
      wr_vld = 1'b0;
   endtask

   // close the load after the last write and follow its programming period
   task automatic end_load();
      bit need;
      int p0;
      need = m_touch || (m_pend != 0);
      p0 = n_prog;
      for (int i = 1; i < BLC; i++) begin
         @(negedge clk);
         if (i == BLC - 2) chk(prog_start == 1'b0, "R8", "prog_start early", prog_start, 0);
         if (i == BLC - 1) begin
            chk(prog_start == need, "R8", "prog_start at window end", prog_start, need);
            chk(prot_on == m_prot, "R1", "flag held until period end", prot_on, m_prot);
         end
      end
      repeat (PRG + 3) @(negedge clk);
      if (need && m_pend == 1) m_prot = 1;
      if (need && m_pend == 2) m_prot = 0;
      chk(n_prog - p0 == int'(need), "R5", "programming starts", n_prog - p0, need);
      chk(prot_on == m_prot, (m_pend == 2) ? "R2" : "R1", "prot_on after period", prot_on, m_prot);
      mdl_clear();
   endtask

   task automatic prefix();
      wr(AP, 8'hAA); wr(AS, 8'h55); wr(AP, 8'hA0);
   endtask

   task automatic unlock();
      wr(AP, 8'hAA); wr(AS, 8'h55); wr(AP, 8'h80);
      wr(AP, 8'hAA); wr(AS, 8'h55); wr(AP, 8'h20);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      #1;
      chk(prot_on == 1'b0, "R9", "flag at power-up", prot_on, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(byte_pass == 1'b0 && prog_start == 1'b0, "R9", "outputs after reset",
          byte_pass + prog_start, 0);

      // R4: unprotected plain writes
      wr(15'h0123, 8'h5A); wr(15'h0124, 8'hC3); end_load();
      // R1: prefix alone locks
      prefix(); end_load();
      // R5: unauthorised load blocked, timer still runs
      wr(15'h1000, 8'h11); wr(AP, 8'h77); end_load();
      // R6: prefix followed by data
      prefix(); wr(15'h0200, 8'h01); wr(15'h0201, 8'h02); end_load();
      // R7: broken sequence under protection
      wr(AP, 8'hAA); wr(AS, 8'h55); wr(AP, 8'h33); wr(15'h0300, 8'h44); end_load();
      // R8: incomplete prefix times out, no programming, flag kept
      wr(AP, 8'hAA); wr(AS, 8'h55); end_load();
      // R9: reset leaves the flag alone
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(prot_on == 1'b1, "R9", "flag across reset", prot_on, 1);
      // R2: unlock with data
      unlock(); wr(15'h0400, 8'h99); end_load();
      // R8: timed-out match does not continue into next load
      wr(AP, 8'hAA); wr(AS, 8'h55); end_load();
      wr(AP, 8'h80); end_load();
      // R7: break unprotected sequence at step four
      wr(AP, 8'hAA); wr(AS, 8'h55); wr(AP, 8'h80); wr(AP, 8'h21); end_load();

      for (int l = 0; l < 120; l++) begin
         int kind, nd, steps;
         kind = $urandom_range(0, 4);
         if (kind == 1) prefix();
         else if (kind == 2) unlock();
         else if (kind >= 3) begin
            steps = $urandom_range(1, 5);
            for (int s = 0; s < steps; s++) begin
               repeat ($urandom_range(0, BLC - 3)) @(negedge clk);
               wr(m_addr(s), m_key(s));
            end
            if (kind == 3) wr(m_addr(steps), 8'h3C);
         end
         nd = (kind == 4) ? 0 : $urandom_range((kind == 0) ? 1 : 0, 4);
         for (int b = 0; b < nd; b++) begin
            repeat ($urandom_range(0, BLC - 3)) @(negedge clk);
            wr(15'($urandom), 8'($urandom));
         end
         end_load();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule